// File: doc/BRIEF.md
# Keyed-MAC Message Byte Sequencer

This block produces the exact byte stream that a hash engine consumes when it computes a keyed message authentication code. The stream is 88 bytes long and has a fixed order. It contains the 32 bytes of a selected key slot and the 32 bytes of a temporary key register. Then come four header bytes: the command opcode, the mode, and a 16-bit slot parameter. After those come the first eleven bytes of a one-time-programmable area and the nine serial-number bytes, which are sent in a permuted order.

The key, temporary-key, OTP and serial-number storage sit outside the block as register arrays with combinational read ports. The block drives one read address per array and forwards the returned byte. It inserts the header bytes itself. It presents each byte on a valid/ready stream and flags the final byte. A single-cycle start pulse carries the mode byte and a 4-bit slot index. Both values are captured at that moment and used for the rest of the message.

Top module: `mac_msg_sequencer`

## Requirements
- R1: After reset, `busy_o` and `m_valid_o` are low.
- R2: A start pulse while idle raises `busy_o` and `m_valid_o` on the next cycle. The first byte offered is key byte 0 of the selected slot.
- R3: Stream bytes 0..31 are key bytes 0..31 of the latched slot, in ascending order. The key read address is `{slot, byte_index}`.
- R4: Stream bytes 32..63 are temporary-key bytes 0..31, in ascending order.
- R5: Stream byte 64 is the constant opcode 0x08, and stream byte 65 is the mode byte latched at start.
- R6: Stream byte 66 is the slot index zero-extended to 8 bits, and stream byte 67 is 0x00. The 16-bit parameter is therefore sent low byte first.
- R7: Stream bytes 68..78 are OTP bytes 0..10, in ascending order.
- R8: Stream bytes 79..87 are serial-number bytes in the order 8, 4, 5, 6, 7, 0, 1, 2, 3.
- R9: Each message has exactly 88 bytes. `m_last_o` is high only together with the 88th byte.
- R10: The byte position advances only on a cycle where `m_valid_o` and `m_ready_i` are both high. While `m_ready_i` is low, `m_data_o` and `m_last_o` hold their values.
- R11: A start pulse that arrives while `busy_o` is high is ignored. The slot and mode of the running message do not change, and no extra message follows.
- R12: `busy_o` falls on the cycle after the final byte is accepted. A new start pulse after that begins a fresh message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a message |
| mode_i | input | 8 | Mode byte, captured at start |
| slot_i | input | 4 | Key slot index, captured at start |
| key_addr_o | output | 9 | Key array read address {slot, byte} |
| key_data_i | input | 8 | Key array read data |
| tk_addr_o | output | 5 | Temporary-key read address |
| tk_data_i | input | 8 | Temporary-key read data |
| otp_addr_o | output | 4 | OTP read address |
| otp_data_i | input | 8 | OTP read data |
| sn_addr_o | output | 4 | Serial-number read address |
| sn_data_i | input | 8 | Serial-number read data |
| m_valid_o | output | 1 | Stream byte valid |
| m_ready_i | input | 1 | Stream consumer ready |
| m_data_o | output | 8 | Stream byte |
| m_last_o | output | 1 | Final byte of the message |
| busy_o | output | 1 | Message in progress |

## Verification
The port-level hold property assumes that the storage arrays keep their contents constant while a message is running. The bench meets this by filling its array models once, before the first start pulse. The header and parameter checks assume that `mode_i` and `slot_i` are meaningful only in the start cycle. The bench therefore changes them freely between pulses, including during the ignored mid-message pulses. Ready is driven with three patterns: always high, pseudo-random, and alternating. This exercises stalls at every stream position, including the final byte.

// File: rtl/mac_seq_pkg.sv
package mac_seq_pkg;

    localparam int KEY_BYTES = 32;
    localparam int TK_BYTES  = 32;
    localparam int HDR_BYTES = 4;
    localparam int OTP_BYTES = 11;
    localparam int SN_BYTES  = 9;

    localparam int TK_BASE   = KEY_BYTES;
    localparam int HDR_BASE  = TK_BASE + TK_BYTES;
    localparam int OTP_BASE  = HDR_BASE + HDR_BYTES;
    localparam int SN_BASE   = OTP_BASE + OTP_BYTES;
    localparam int MSG_LEN   = SN_BASE + SN_BYTES;

    localparam logic [7:0] MAC_OPCODE = 8'h08;

    typedef enum logic [2:0] {
        SEG_KEY,
        SEG_TK,
        SEG_OPC,
        SEG_MODE,
        SEG_PLO,
        SEG_PHI,
        SEG_OTP,
        SEG_SN
    } seg_e;

endpackage

// File: rtl/mac_seq_ctrl.sv
module mac_seq_ctrl
    import mac_seq_pkg::*;
#(
    parameter int SLOT_W = 4,
    parameter int DATA_W = 8,
    parameter int LEN    = MSG_LEN,
    localparam int CNT_W = $clog2(LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] mode_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              ready_i,
    output logic              busy_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic [DATA_W-1:0] mode_o,
    output logic              final_o
);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [SLOT_W-1:0] slot;
        logic [DATA_W-1:0] mode;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  at_end;
    logic  take;

    always_comb begin
        st_d   = st_q;
        at_end = (st_q.cnt == CNT_W'(LEN - 1));
        take   = st_q.busy && ready_i;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
                st_d.slot = slot_i;
                st_d.mode = mode_i;
            end
        end else if (take) begin
            if (at_end) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o  = st_q.busy;
    assign cnt_o   = st_q.cnt;
    assign slot_o  = st_q.slot;
    assign mode_o  = st_q.mode;
    assign final_o = st_q.busy && at_end;

    // R2
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && start_i |=> busy_o && (cnt_o == '0));

    // R10
    no_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !ready_i |=> busy_o && $stable(cnt_o));

    // R11
    ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i |=> $stable(slot_o) && $stable(mode_o));

    // R12
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        final_o && ready_i |=> !busy_o);

    // R9
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (cnt_o < CNT_W'(LEN)));

endmodule

// File: rtl/mac_seq_decode.sv
module mac_seq_decode
    import mac_seq_pkg::*;
#(
    parameter int LEN    = MSG_LEN,
    parameter int IDX_W  = $clog2(KEY_BYTES),
    localparam int CNT_W = $clog2(LEN)
) (
    input  logic [CNT_W-1:0] cnt_i,
    output seg_e             seg_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        seg_o = SEG_KEY;
        idx_o = IDX_W'(cnt_i);
        if (cnt_i < CNT_W'(TK_BASE)) begin
            seg_o = SEG_KEY;
            idx_o = IDX_W'(cnt_i);
        end else if (cnt_i < CNT_W'(HDR_BASE)) begin
            seg_o = SEG_TK;
            idx_o = IDX_W'(cnt_i - CNT_W'(TK_BASE));
        end else if (cnt_i < CNT_W'(OTP_BASE)) begin
            idx_o = IDX_W'(cnt_i - CNT_W'(HDR_BASE));
            case (idx_o[1:0])
                2'd0:    seg_o = SEG_OPC;
                2'd1:    seg_o = SEG_MODE;
                2'd2:    seg_o = SEG_PLO;
                default: seg_o = SEG_PHI;
            endcase
        end else if (cnt_i < CNT_W'(SN_BASE)) begin
            seg_o = SEG_OTP;
            idx_o = IDX_W'(cnt_i - CNT_W'(OTP_BASE));
        end else begin
            seg_o = SEG_SN;
            idx_o = IDX_W'(cnt_i - CNT_W'(SN_BASE));
        end
    end

endmodule

// File: rtl/mac_seq_addr.sv
module mac_seq_addr
    import mac_seq_pkg::*;
#(
    parameter int SLOT_W  = 4,
    parameter int IDX_W   = $clog2(KEY_BYTES),
    localparam int KEY_AW = SLOT_W + $clog2(KEY_BYTES),
    localparam int TK_AW  = $clog2(TK_BYTES),
    localparam int OTP_AW = $clog2(OTP_BYTES),
    localparam int SN_AW  = $clog2(SN_BYTES),
    localparam int SN_GRP = (SN_BYTES - 1) / 2
) (
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [KEY_AW-1:0] key_addr_o,
    output logic [TK_AW-1:0]  tk_addr_o,
    output logic [OTP_AW-1:0] otp_addr_o,
    output logic [SN_AW-1:0]  sn_addr_o
);

    // Serial order: top byte first, then the upper group, then the lower group.
    function automatic logic [SN_AW-1:0] sn_perm(input logic [IDX_W-1:0] pos);
        if (pos == '0)
            return SN_AW'(SN_BYTES - 1);
        else if (pos <= IDX_W'(SN_GRP))
            return SN_AW'(pos + IDX_W'(SN_GRP - 1));
        else
            return SN_AW'(pos - IDX_W'(SN_GRP + 1));
    endfunction

    always_comb begin
        key_addr_o = {slot_i, idx_i[$clog2(KEY_BYTES)-1:0]};
        tk_addr_o  = TK_AW'(idx_i);
        otp_addr_o = OTP_AW'(idx_i);
        sn_addr_o  = sn_perm(idx_i);
    end

endmodule

// File: rtl/mac_seq_mux.sv
module mac_seq_mux
    import mac_seq_pkg::*;
#(
    parameter int SLOT_W = 4,
    parameter int DATA_W = 8
) (
    input  seg_e              seg_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [DATA_W-1:0] mode_i,
    input  logic [DATA_W-1:0] key_data_i,
    input  logic [DATA_W-1:0] tk_data_i,
    input  logic [DATA_W-1:0] otp_data_i,
    input  logic [DATA_W-1:0] sn_data_i,
    output logic [DATA_W-1:0] byte_o
);

    always_comb begin
        unique case (seg_i)
            SEG_KEY:  byte_o = key_data_i;
            SEG_TK:   byte_o = tk_data_i;
            SEG_OPC:  byte_o = DATA_W'(MAC_OPCODE);
            SEG_MODE: byte_o = mode_i;
            SEG_PLO:  byte_o = DATA_W'(slot_i);
            SEG_PHI:  byte_o = '0;
            SEG_OTP:  byte_o = otp_data_i;
            SEG_SN:   byte_o = sn_data_i;
            default:  byte_o = '0;
        endcase
    end

endmodule

// File: rtl/mac_msg_sequencer.sv
module mac_msg_sequencer
    import mac_seq_pkg::*;
#(
    parameter int SLOT_W  = 4,
    parameter int DATA_W  = 8,
    localparam int KEY_AW = SLOT_W + $clog2(KEY_BYTES),
    localparam int TK_AW  = $clog2(TK_BYTES),
    localparam int OTP_AW = $clog2(OTP_BYTES),
    localparam int SN_AW  = $clog2(SN_BYTES),
    localparam int IDX_W  = $clog2(KEY_BYTES),
    localparam int CNT_W  = $clog2(MSG_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] mode_i,
    input  logic [SLOT_W-1:0] slot_i,
    output logic [KEY_AW-1:0] key_addr_o,
    input  logic [DATA_W-1:0] key_data_i,
    output logic [TK_AW-1:0]  tk_addr_o,
    input  logic [DATA_W-1:0] tk_data_i,
    output logic [OTP_AW-1:0] otp_addr_o,
    input  logic [DATA_W-1:0] otp_data_i,
    output logic [SN_AW-1:0]  sn_addr_o,
    input  logic [DATA_W-1:0] sn_data_i,
    output logic              m_valid_o,
    input  logic              m_ready_i,
    output logic [DATA_W-1:0] m_data_o,
    output logic              m_last_o,
    output logic              busy_o
);

    logic [CNT_W-1:0]  cnt;
    logic [SLOT_W-1:0] slot_q;
    logic [DATA_W-1:0] mode_q;
    logic              final_byte;
    seg_e              seg;
    logic [IDX_W-1:0]  idx;

    mac_seq_ctrl #(.SLOT_W(SLOT_W), .DATA_W(DATA_W), .LEN(MSG_LEN)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .mode_i  (mode_i),
        .slot_i  (slot_i),
        .ready_i (m_ready_i),
        .busy_o  (busy_o),
        .cnt_o   (cnt),
        .slot_o  (slot_q),
        .mode_o  (mode_q),
        .final_o (final_byte)
    );

    mac_seq_decode #(.LEN(MSG_LEN), .IDX_W(IDX_W)) u_decode (
        .cnt_i (cnt),
        .seg_o (seg),
        .idx_o (idx)
    );

    mac_seq_addr #(.SLOT_W(SLOT_W), .IDX_W(IDX_W)) u_addr (
        .slot_i     (slot_q),
        .idx_i      (idx),
        .key_addr_o (key_addr_o),
        .tk_addr_o  (tk_addr_o),
        .otp_addr_o (otp_addr_o),
        .sn_addr_o  (sn_addr_o)
    );

    mac_seq_mux #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_mux (
        .seg_i      (seg),
        .slot_i     (slot_q),
        .mode_i     (mode_q),
        .key_data_i (key_data_i),
        .tk_data_i  (tk_data_i),
        .otp_data_i (otp_data_i),
        .sn_data_i  (sn_data_i),
        .byte_o     (m_data_o)
    );

    assign m_valid_o = busy_o;
    assign m_last_o  = final_byte;

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid_o && !m_ready_i |=> m_valid_o && $stable(m_data_o) && $stable(m_last_o));

    // R9
    last_in_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_last_o |-> m_valid_o);

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !m_valid_o);

endmodule

// File: tb/tb_mac_msg_sequencer.sv
module tb_mac_msg_sequencer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] mode_i = '0;
    logic [3:0] slot_i = '0;
    logic [8:0] key_addr;
    logic [4:0] tk_addr;
    logic [3:0] otp_addr, sn_addr;
    logic [7:0] key_data, tk_data, otp_data, sn_data;
    logic       m_valid, m_ready, m_last, busy;
    logic [7:0] m_data;

    logic [7:0] key_mem [512];
    logic [7:0] tk_mem  [32];
    logic [7:0] otp_mem [16];
    logic [7:0] sn_mem  [16];

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int ready_mode = 0;
    logic [8:0] exp_q [$];
    string      tag_q [$];
    logic       hold_f = 1'b0;
    logic [7:0] hold_d;
    logic       hold_l;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign key_data = key_mem[key_addr];
    assign tk_data  = tk_mem[tk_addr];
    assign otp_data = otp_mem[otp_addr];
    assign sn_data  = sn_mem[sn_addr];

    mac_msg_sequencer dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .slot_i(slot_i),
        .key_addr_o(key_addr), .key_data_i(key_data),
        .tk_addr_o(tk_addr), .tk_data_i(tk_data),
        .otp_addr_o(otp_addr), .otp_data_i(otp_data),
        .sn_addr_o(sn_addr), .sn_data_i(sn_data),
        .m_valid_o(m_valid), .m_ready_i(m_ready), .m_data_o(m_data),
        .m_last_o(m_last), .busy_o(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Scoreboard monitor: ready is chosen at the falling edge, then the byte is compared
    always @(negedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            check(1'b0, "watchdog", cycles, 0);
            summary();
        end
        if (hold_f && rst_n) begin
            check(m_valid && m_data == hold_d && m_last == hold_l, "R10 stall hold",
                  {m_valid, m_last, m_data}, {1'b1, hold_l, hold_d});
        end
        hold_f = 1'b0;
        case (ready_mode)
            0: m_ready = 1'b1;
            1: m_ready = ($urandom % 3) != 0;
            default: m_ready = (cycles % 2) == 0;
        endcase
        if (m_valid && m_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 extra byte", m_data, 0);
            end else begin
                logic [8:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({m_last, m_data} == e, t, {m_last, m_data}, e);
            end
        end else if (m_valid) begin
            hold_f = 1'b1;
            hold_d = m_data;
            hold_l = m_last;
        end
    end

    task automatic push(input logic [7:0] d, input bit last, input string t);
        exp_q.push_back({last, d});
        tag_q.push_back(t);
    endtask

    // Driver: queue the expected stream, then pulse start
    task automatic run_msg(input logic [3:0] slot, input logic [7:0] mode, input bit mid_start);
        for (int i = 0; i < 32; i++) push(key_mem[{slot, 5'(i)}], 1'b0, "R3 key byte");
        for (int i = 0; i < 32; i++) push(tk_mem[i], 1'b0, "R4 temp key byte");
        push(8'h08, 1'b0, "R5 opcode");
        push(mode, 1'b0, "R5 mode");
        push({4'h0, slot}, 1'b0, "R6 param low");
        push(8'h00, 1'b0, "R6 param high");
        for (int i = 0; i < 11; i++) push(otp_mem[i], 1'b0, "R7 otp byte");
        push(sn_mem[8], 1'b0, "R8 serial");
        for (int i = 4; i < 8; i++) push(sn_mem[i], 1'b0, "R8 serial");
        for (int i = 0; i < 3; i++) push(sn_mem[i], 1'b0, "R8 serial");
        push(sn_mem[3], 1'b1, "R9 final serial with last");
        @(negedge clk);
        start_i = 1'b1; slot_i = slot; mode_i = mode;
        @(negedge clk);
        start_i = 1'b0; slot_i = ~slot; mode_i = ~mode;
        check(busy && m_valid, "R2 busy after start", {busy, m_valid}, 3);
        if (mid_start) begin
            repeat (20) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        wait (exp_q.size() == 0);
        @(negedge clk);
        check(!busy && !m_valid, "R12 idle after last accept", busy, 0);
        repeat (3) @(negedge clk);
        check(!busy && !m_valid, "R11 no extra message", busy, 0);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) key_mem[i] = 8'((i * 37 + 11) ^ (i >> 5));
        for (int i = 0; i < 32; i++)  tk_mem[i]  = 8'hA0 ^ 8'(i * 5);
        for (int i = 0; i < 16; i++)  otp_mem[i] = 8'h50 + 8'(i);
        for (int i = 0; i < 16; i++)  sn_mem[i]  = 8'hC0 + 8'(i * 3);
        m_ready = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !m_valid, "R1 reset state", {busy, m_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !m_valid, "R1 idle after reset", {busy, m_valid}, 0);
        ready_mode = 0; run_msg(4'd3, 8'h71, 1'b0);
        ready_mode = 1; run_msg(4'd15, 8'h00, 1'b1);
        ready_mode = 2; run_msg(4'd0, 8'hFF, 1'b0);
        ready_mode = 1; run_msg(4'd9, 8'h5A, 1'b1);
        ready_mode = 0; run_msg(4'd7, 8'h71, 1'b0);
        summary();
    end

endmodule